// File: doc/BRIEF.md
# Data Pointer Address Generation Unit

This block computes the effective data address for a load or store. The address comes either straight from a 16-bit immediate or from one of three 16-bit pointer registers. In pointer-based modes the unit can add a small unsigned offset to the pointer, or it can step the pointer down or up by one. When the pointer is stepped, the unit returns the new pointer value with a write-back enable, so the register file can store it in the same operation.

The surrounding pipeline presents one request per cycle on `req_valid`, together with the mode, the pointer select, the offset, the immediate and the current contents of the three pointers. The result registers on the next rising edge. A two-state controller tracks whether a result is on the outputs. In ST_IDLE no result is presented. A cycle with `req_valid` high moves the controller to ST_RESULT (transition IDLE_TO_RESULT), or keeps it there if it is already in ST_RESULT (RESULT_HOLD). A cycle without a request moves it from ST_RESULT back to ST_IDLE (RESULT_TO_IDLE), or keeps it in ST_IDLE (IDLE_HOLD).

Mode codes on `req_mode` are: 0 direct, 1 pointer, 2 pointer plus offset, 3 decrement-then-use, 4 use-then-increment, and 5 to 7 reserved. Pointer select codes on `req_ptr_sel` are: 0 the X pointer, 1 the Y pointer, 2 the Z pointer, and 3 no pointer.

Top module: `data_ptr_agu`

## Requirements
- R1: While reset is asserted and after reset until the first request, res_valid, res_wb_en and res_illegal are 0, and res_addr, res_ptr_new and res_wb_sel are 0.
- R2: Mode 0 (direct) gives res_addr equal to req_imm over the full 0x0000 to 0xFFFF range. The pointer inputs and the pointer select have no effect, and res_wb_en is 0.
- R3: Mode 1 gives res_addr equal to the selected pointer (select code 0 for X, 1 for Y, 2 for Z), with res_wb_en 0.
- R4: Mode 2 with select code 1 or 2 gives res_addr equal to the pointer plus the zero-extended 6-bit req_disp (0 to 63), modulo 2^16, with res_wb_en 0.
- R5: Mode 2 with select code 0 (X) gives res_illegal 1, res_wb_en 0 and res_addr 0.
- R6: Mode 3 gives res_addr and res_ptr_new both equal to the selected pointer minus 1 modulo 2^16, with res_wb_en 1.
- R7: Mode 4 gives res_addr equal to the selected pointer and res_ptr_new equal to the pointer plus 1 modulo 2^16, with res_wb_en 1.
- R8: A request accepted at a rising edge appears with res_valid 1 immediately after that edge, one result per request and in order. After an edge with req_valid 0, res_valid is 0 and all result outputs are 0.
- R9: The reserved mode codes 5 to 7, and select code 3 in modes 1 to 4, give res_illegal 1, res_wb_en 0, res_addr 0 and res_ptr_new 0.
- R10: res_wb_en is 1 only for legal mode 3 or mode 4 requests. In that case res_wb_sel equals the request's select code; otherwise res_wb_sel and res_ptr_new are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_ptr_sel | input | 2 | Pointer select code |
| req_disp | input | 6 | Unsigned offset for mode 2 |
| req_imm | input | 16 | Immediate address for mode 0 |
| ptr_x | input | 16 | Current X pointer value |
| ptr_y | input | 16 | Current Y pointer value |
| ptr_z | input | 16 | Current Z pointer value |
| res_valid | output | 1 | Result present |
| res_addr | output | 16 | Effective address |
| res_ptr_new | output | 16 | Updated pointer for write-back |
| res_wb_en | output | 1 | Write-back enable |
| res_wb_sel | output | 2 | Pointer to write back |
| res_illegal | output | 1 | Illegal mode or pointer combination |

## Verification
Direct mode is driven with the extreme immediates 0x0000 and 0xFFFF while the pointers hold unrelated values, which separates immediate routing from pointer routing. Each pointer is given a distinct value, so a wrong select shows up as a wrong address. Offsets of 0 and 63 are applied to a base near 0xFFFF, which exposes a dropped offset bit or missing wrap-around. The decrement and increment modes are run on 0x0000 and 0xFFFF, which tells modulo arithmetic apart from saturation and distinguishes pre-update from post-update addressing. Back-to-back requests followed by an idle cycle separate correct per-cycle capture and result ordering from stale or repeated results.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_DIRECT   = 3'd0,
        AM_IND      = 3'd1,
        AM_IND_DISP = 3'd2,
        AM_PRE_DEC  = 3'd3,
        AM_POST_INC = 3'd4
    } mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux #(
    parameter int NUM_PTR = 3,
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 2,
    parameter logic [NUM_PTR-1:0] DISP_MASK = '1
) (
    input  logic [NUM_PTR*ADDR_W-1:0] ptr_flat_i,
    input  logic [SEL_W-1:0]          sel_i,
    output logic [ADDR_W-1:0]         ptr_o,
    output logic                      sel_ok_o,
    output logic                      disp_ok_o
);

    logic [NUM_PTR-1:0] hit;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_hit
        assign hit[g] = (sel_i == SEL_W'(g));
    end

    always_comb begin
        ptr_o = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (hit[i]) begin
                ptr_o = ptr_o | ptr_flat_i[i*ADDR_W +: ADDR_W];
            end
        end
    end

    assign sel_ok_o  = |hit;
    assign disp_ok_o = |(hit & DISP_MASK);

    // R3: a decoded select is at most one pointer
    always_comb begin
        assert_sel_onehot_R3: assert ($onehot0(hit));
    end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  mode_e              mode_i,
    input  logic [DISP_W-1:0]  disp_i,
    input  logic [ADDR_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0]  ptr_i,
    input  logic               sel_ok_i,
    input  logic               disp_ok_i,
    output logic [ADDR_W-1:0]  ea_o,
    output logic [ADDR_W-1:0]  ptr_new_o,
    output logic               wb_o,
    output logic               illegal_o
);

    localparam int PAD_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] ptr_dec;
    logic [ADDR_W-1:0] ptr_inc;

    assign disp_ext = {{PAD_W{1'b0}}, disp_i};
    assign ptr_dec  = ptr_i - ADDR_W'(1);
    assign ptr_inc  = ptr_i + ADDR_W'(1);

    always_comb begin
        ea_o      = '0;
        ptr_new_o = '0;
        wb_o      = 1'b0;
        illegal_o = 1'b0;
        unique case (mode_i)
            AM_DIRECT: begin
                ea_o = imm_i;
            end
            AM_IND: begin
                if (sel_ok_i) ea_o = ptr_i;
                else          illegal_o = 1'b1;
            end
            AM_IND_DISP: begin
                if (disp_ok_i) ea_o = ptr_i + disp_ext;
                else           illegal_o = 1'b1;
            end
            AM_PRE_DEC: begin
                if (sel_ok_i) begin
                    ea_o      = ptr_dec;
                    ptr_new_o = ptr_dec;
                    wb_o      = 1'b1;
                end else begin
                    illegal_o = 1'b1;
                end
            end
            AM_POST_INC: begin
                if (sel_ok_i) begin
                    ea_o      = ptr_i;
                    ptr_new_o = ptr_inc;
                    wb_o      = 1'b1;
                end else begin
                    illegal_o = 1'b1;
                end
            end
            default: begin
                illegal_o = 1'b1;
            end
        endcase
    end

    // R5 / R9: an illegal request never writes a pointer back
    always_comb begin
        assert_illegal_no_wb_R5: assert (!(illegal_o && wb_o));
    end

endmodule

// File: rtl/data_ptr_agu.sv
module data_ptr_agu
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DISP_W  = 6,
    parameter int NUM_PTR = 3,
    parameter logic [NUM_PTR-1:0] DISP_MASK = 3'b110,
    localparam int SEL_W  = $clog2(NUM_PTR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [SEL_W-1:0]  req_ptr_sel,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [ADDR_W-1:0] req_imm,
    input  logic [ADDR_W-1:0] ptr_x,
    input  logic [ADDR_W-1:0] ptr_y,
    input  logic [ADDR_W-1:0] ptr_z,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic [ADDR_W-1:0] res_ptr_new,
    output logic              res_wb_en,
    output logic [SEL_W-1:0]  res_wb_sel,
    output logic              res_illegal
);

    logic [NUM_PTR*ADDR_W-1:0] ptr_flat;
    logic [ADDR_W-1:0]         ptr_sel;
    logic                      sel_ok;
    logic                      disp_ok;
    logic [ADDR_W-1:0]         ea_c;
    logic [ADDR_W-1:0]         ptr_new_c;
    logic                      wb_c;
    logic                      illegal_c;

    assign ptr_flat = {ptr_z, ptr_y, ptr_x};

    agu_ptr_mux #(
        .NUM_PTR   (NUM_PTR),
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W),
        .DISP_MASK (DISP_MASK)
    ) u_ptr_mux (
        .ptr_flat_i (ptr_flat),
        .sel_i      (req_ptr_sel),
        .ptr_o      (ptr_sel),
        .sel_ok_o   (sel_ok),
        .disp_ok_o  (disp_ok)
    );

    agu_addr_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_addr_calc (
        .mode_i    (mode_e'(req_mode)),
        .disp_i    (req_disp),
        .imm_i     (req_imm),
        .ptr_i     (ptr_sel),
        .sel_ok_i  (sel_ok),
        .disp_ok_i (disp_ok),
        .ea_o      (ea_c),
        .ptr_new_o (ptr_new_c),
        .wb_o      (wb_c),
        .illegal_o (illegal_c)
    );

    // controller
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ptr_new_q;
    logic              wb_q;
    logic [SEL_W-1:0]  wb_sel_q;
    logic              illegal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            ptr_new_q <= '0;
            wb_q      <= 1'b0;
            wb_sel_q  <= '0;
            illegal_q <= 1'b0;
        end else if (req_valid) begin
            addr_q    <= ea_c;
            ptr_new_q <= ptr_new_c;
            wb_q      <= wb_c;
            wb_sel_q  <= wb_c ? req_ptr_sel : '0;
            illegal_q <= illegal_c;
        end
    end

    // output process
    always_comb begin
        res_valid   = 1'b0;
        res_addr    = '0;
        res_ptr_new = '0;
        res_wb_en   = 1'b0;
        res_wb_sel  = '0;
        res_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESULT: begin
                res_valid   = 1'b1;
                res_addr    = addr_q;
                res_ptr_new = ptr_new_q;
                res_wb_en   = wb_q;
                res_wb_sel  = wb_sel_q;
                res_illegal = illegal_q;
            end
            default: ;
        endcase
    end

    // assertions
    assert_req_gives_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_wb_en && res_addr == '0));

    assert_direct_imm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_DIRECT) |=> (res_addr == $past(req_imm) && !res_wb_en));

    assert_ind_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_IND && req_ptr_sel == SEL_W'(1))
        |=> (res_addr == $past(ptr_y)));

    assert_x_disp_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_IND_DISP && req_ptr_sel == SEL_W'(0))
        |=> (res_illegal && !res_wb_en));

    assert_predec_addr_eq_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_PRE_DEC && req_ptr_sel != SEL_W'(3))
        |=> (res_wb_en && res_addr == res_ptr_new));

    assert_postinc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_POST_INC && req_ptr_sel != SEL_W'(3))
        |=> (res_wb_en && res_ptr_new == res_addr + ADDR_W'(1)));

    assert_reserved_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode > MODE_W'(4)) |=> (res_illegal && !res_wb_en));

    assert_wb_only_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != AM_PRE_DEC && req_mode != AM_POST_INC)
        |=> (!res_wb_en && res_wb_sel == '0));

endmodule

// File: tb/data_ptr_agu_tb.sv
`timescale 1ns/1ps
module data_ptr_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_ptr_sel = '0;
    logic [5:0]  req_disp = '0;
    logic [15:0] req_imm = '0;
    logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
    logic        res_valid;
    logic [15:0] res_addr, res_ptr_new;
    logic        res_wb_en;
    logic [1:0]  res_wb_sel;
    logic        res_illegal;

    always #2.5 clk = ~clk;

    data_ptr_agu u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_ptr_sel(req_ptr_sel), .req_disp(req_disp), .req_imm(req_imm),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .res_valid(res_valid), .res_addr(res_addr), .res_ptr_new(res_ptr_new),
        .res_wb_en(res_wb_en), .res_wb_sel(res_wb_sel), .res_illegal(res_illegal)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] pnew;
        logic        wb;
        logic [1:0]  wsel;
        logic        ill;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    tests = 0;
    int    fails = 0;
    bit    done  = 1'b0;

    function automatic exp_t model(input logic [2:0] m, input logic [1:0] s,
                                   input logic [5:0] d, input logic [15:0] im,
                                   input logic [15:0] x, input logic [15:0] y,
                                   input logic [15:0] z);
        exp_t e = '0;
        logic [15:0] p;
        p = (s == 2'd0) ? x : (s == 2'd1) ? y : (s == 2'd2) ? z : 16'h0;
        case (m)
            3'd0: e.addr = im;
            3'd1: if (s == 2'd3) e.ill = 1'b1; else e.addr = p;
            3'd2: if (s == 2'd1 || s == 2'd2) e.addr = p + {10'd0, d}; else e.ill = 1'b1;
            3'd3: if (s == 2'd3) e.ill = 1'b1;
                  else begin e.addr = p - 16'd1; e.pnew = p - 16'd1; e.wb = 1'b1; e.wsel = s; end
            3'd4: if (s == 2'd3) e.ill = 1'b1;
                  else begin e.addr = p; e.pnew = p + 16'd1; e.wb = 1'b1; e.wsel = s; end
            default: e.ill = 1'b1;
        endcase
        return e;
    endfunction

    // driver: called right after a falling edge
    task automatic drive(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                         input logic [15:0] im, input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] z, input string tag);
        req_valid = 1'b1; req_mode = m; req_ptr_sel = s; req_disp = d; req_imm = im;
        ptr_x = x; ptr_y = y; ptr_z = z;
        exp_q.push_back(model(m, s, d, im, x, y, z));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        req_mode = 3'd0; req_ptr_sel = 2'd0; req_disp = '0; req_imm = 16'h5A5A;
        @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && res_valid) begin
                exp_t g, e;
                string t;
                g = {res_addr, res_ptr_new, res_wb_en, res_wb_sel, res_illegal};
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected result: got %h expected no result", g);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (g !== e) begin
                        fails++;
                        $display("FAIL %s: got addr=%h new=%h wb=%b sel=%0d ill=%b, expected addr=%h new=%h wb=%b sel=%0d ill=%b",
                                 t, g.addr, g.pnew, g.wb, g.wsel, g.ill,
                                 e.addr, e.pnew, e.wb, e.wsel, e.ill);
                    end
                end
            end
        end
    end

    task automatic check_quiet(input string tag);
        tests++;
        if (res_valid !== 1'b0 || res_wb_en !== 1'b0 || res_illegal !== 1'b0 ||
            res_addr !== 16'h0 || res_ptr_new !== 16'h0 || res_wb_sel !== 2'd0) begin
            fails++;
            $display("FAIL %s: got valid=%b addr=%h new=%h wb=%b sel=%0d ill=%b, expected all zero",
                     tag, res_valid, res_addr, res_ptr_new, res_wb_en, res_wb_sel, res_illegal);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no completion, expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_quiet("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_quiet("R1 after reset release");
        @(negedge clk);

        // R2 direct, pointers hold unrelated values
        drive(3'd0, 2'd1, 6'd9,  16'hFFFF, 16'h1111, 16'h2222, 16'h3333, "R2 direct FFFF");
        drive(3'd0, 2'd2, 6'd63, 16'h0000, 16'hAAAA, 16'hBBBB, 16'hCCCC, "R2 direct 0000");
        // R3 plain pointer
        drive(3'd1, 2'd0, 6'd0, 16'h0, 16'h1234, 16'h5678, 16'h9ABC, "R3 ind X");
        drive(3'd1, 2'd1, 6'd0, 16'h0, 16'h1234, 16'h5678, 16'h9ABC, "R3 ind Y");
        drive(3'd1, 2'd2, 6'd0, 16'h0, 16'h1234, 16'h5678, 16'h9ABC, "R3 ind Z");
        // R4 displacement
        drive(3'd2, 2'd1, 6'd0,  16'h0, 16'h0100, 16'h0200, 16'h0300, "R4 disp Y 0");
        drive(3'd2, 2'd1, 6'd63, 16'h0, 16'h0100, 16'h0200, 16'h0300, "R4 disp Y 63");
        drive(3'd2, 2'd2, 6'd63, 16'h0, 16'h0100, 16'h0200, 16'hFFF0, "R4 disp Z wrap");
        // R5 displacement on X
        drive(3'd2, 2'd0, 6'd5,  16'h0, 16'h4000, 16'h0200, 16'h0300, "R5 disp X illegal");
        // R6 pre-decrement
        drive(3'd3, 2'd0, 6'd0, 16'h0, 16'h1000, 16'h0200, 16'h0300, "R6 predec X");
        drive(3'd3, 2'd2, 6'd0, 16'h0, 16'h1000, 16'h0200, 16'h0000, "R6 predec Z wrap R10");
        // R7 post-increment
        drive(3'd4, 2'd1, 6'd0, 16'h0, 16'h1000, 16'h00FF, 16'h0300, "R7 postinc Y");
        drive(3'd4, 2'd0, 6'd0, 16'h0, 16'hFFFF, 16'h00FF, 16'h0300, "R7 postinc X wrap R10");
        // R9 reserved codes
        drive(3'd5, 2'd1, 6'd0, 16'h7777, 16'h1, 16'h2, 16'h3, "R9 mode 5");
        drive(3'd7, 2'd0, 6'd0, 16'h7777, 16'h1, 16'h2, 16'h3, "R9 mode 7");
        drive(3'd1, 2'd3, 6'd0, 16'h7777, 16'h1, 16'h2, 16'h3, "R9 ind sel 3");
        drive(3'd3, 2'd3, 6'd0, 16'h7777, 16'h1, 16'h2, 16'h3, "R9 predec sel 3");

        // R8 idle after back-to-back stream
        idle();
        #1;
        check_quiet("R8 idle cycle");
        @(negedge clk);
        // R8 single request after idle
        drive(3'd0, 2'd0, 6'd0, 16'hBEEF, 16'h0, 16'h0, 16'h0, "R8 single after idle");
        idle();
        idle();

        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8 results missing: got %0d pending, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule